// File: doc/BRIEF.md
# Phase Resynchronization Sync Timer

This block produces the internal sync pulses that a fractional-N synthesizer uses to pull its output phase back to a fixed offset from the reference. It counts enabled cycles of the phase-detector reference. A two-level count sets the interval. An inner stage runs over the delay value and an outer stage runs over the multiplier value. A single-cycle sync pulse is issued each time both stages complete, so the pulse period is multiplier times delay reference cycles.

Software loads a new frequency word by raising a load strobe. That rising edge arms the timer. The first sync pulse that follows is let through without action. The second one is flagged as the resync event on a separate single-cycle apply strobe. This gives the loop one full interval to finish settling before the phase is realigned.

If the multiplier or the delay is zero, the function is switched off. All pins are plain control and status lines. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `resync_timer`

## Requirements
- R1: `sync_o` is high for exactly one clock cycle once every `mult_i` × `delay_i` enabled reference cycles, counted from the last restart. It rises on the clock edge after the enabled cycle that completes the interval.
- R2: A cycle with `pfd_en` low does not advance the interval count.
- R3: When `mult_i` or `delay_i` is zero, the block is disabled. In that state `sync_o` and `apply_o` stay low, `pending_o` is cleared, and a load edge does not arm the block.
- R4: A rising edge on `load_i`, or any change of `mult_i` or `delay_i`, restarts the interval count from zero. No sync pulse is produced for that cycle.
- R5: A rising edge on `load_i` while the block is enabled makes `pending_o` high from the next cycle on.
- R6: After arming, the first sync pulse leaves `apply_o` low and `pending_o` high. The second sync pulse has `apply_o` high in the same cycle, and `pending_o` falls in that same cycle.
- R7: A new rising edge on `load_i` while a resync is pending re-arms the block. The count toward the second pulse starts over from that load.
- R8: Holding `load_i` high over several cycles acts as a single load. Only the low-to-high transition counts.
- R9: With `mult_i` = 10 and `delay_i` = 1000, and the enable always high, sync pulses are exactly 10,000 cycles apart.
- R10: `apply_o` is never high without `sync_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pfd_en | input | 1 | One-cycle enable per reference (phase-detector) period |
| load_i | input | 1 | New-frequency load strobe; its rising edge is the event |
| mult_i | input | 4 | Interval multiplier, 1..15; 0 disables |
| delay_i | input | 11 | Interval delay in reference cycles; 0 disables |
| sync_o | output | 1 | Periodic sync pulse |
| apply_o | output | 1 | Resync-apply strobe, high with the second sync after a load |
| pending_o | output | 1 | High while a resync is armed and not yet applied |

## Verification
A wrong inner or outer count shows up as a sync pulse that arrives early or late. The error is visible at the first pulse after a restart, which comes at most one interval after the fault. A fault in the arming state machine shows up in one of three ways: `apply_o` on the first sync instead of the second, `pending_o` not dropping, or a re-arm that is ignored. Each of these is visible within two intervals of a load edge. The reference model follows every cycle and checks all three outputs each cycle, so any divergence is caught in the cycle where it first reaches a pin.

// File: rtl/resync_pkg.sv
package resync_pkg;
  localparam int MULT_W_DEF = 4;
  localparam int DLY_W_DEF  = 11;

  typedef enum logic [1:0] {
    ARM_IDLE  = 2'd0,
    ARM_WAIT1 = 2'd1,
    ARM_WAIT2 = 2'd2
  } arm_state_e;
endpackage

// File: rtl/resync_stage_cnt.sv
module resync_stage_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] lim,
  output logic         last
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] lim_m1;

  assign lim_m1 = lim - W'(1);
  assign last   = (cnt_q == lim_m1);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (step)   cnt_q <= last ? '0 : cnt_q + W'(1);
  end

  // R1: a stage that is stepped always sits inside its limit
  a_r1_stage_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |-> (cnt_q < lim));
endmodule

// File: rtl/resync_arm.sv
module resync_arm import resync_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  logic enabled,
  input  logic arm,
  input  logic hit,
  output logic apply_d,
  output logic pending
);
  arm_state_e st_q, st_d;

  always_comb begin
    st_d    = st_q;
    apply_d = 1'b0;
    if (!enabled)      st_d = ARM_IDLE;
    else if (arm)      st_d = ARM_WAIT1;
    else if (hit) begin
      case (st_q)
        ARM_WAIT1: st_d = ARM_WAIT2;
        ARM_WAIT2: begin
          st_d    = ARM_IDLE;
          apply_d = 1'b1;
        end
        default:   st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ARM_IDLE;
    else        st_q <= st_d;
  end

  assign pending = (st_q != ARM_IDLE);

  // R7: an arm request always lands in the first wait state
  a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && enabled) |=> (st_q == ARM_WAIT1));
  // R6: the apply decision only comes from the second wait state
  a_r6_second_only: assert property (@(posedge clk) disable iff (!rst_n)
    apply_d |-> (st_q == ARM_WAIT2));
endmodule

// File: rtl/resync_timer.sv
module resync_timer import resync_pkg::*; #(
  parameter int MULT_W = MULT_W_DEF,
  parameter int DLY_W  = DLY_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pfd_en,
  input  logic              load_i,
  input  logic [MULT_W-1:0] mult_i,
  input  logic [DLY_W-1:0]  delay_i,
  output logic              sync_o,
  output logic              apply_o,
  output logic              pending_o
);
  logic              load_q;
  logic [MULT_W-1:0] mult_q;
  logic [DLY_W-1:0]  dly_q;
  logic load_rise, cfg_chg, restart, enabled, count_step;
  logic in_last, out_last, hit, apply_d;
  logic sync_q, apply_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q <= 1'b0;
      mult_q <= '0;
      dly_q  <= '0;
    end else begin
      load_q <= load_i;
      mult_q <= mult_i;
      dly_q  <= delay_i;
    end
  end

  assign load_rise  = load_i & ~load_q;
  assign cfg_chg    = (mult_i != mult_q) | (delay_i != dly_q);
  assign restart    = load_rise | cfg_chg;
  assign enabled    = (|mult_i) & (|delay_i);
  assign count_step = pfd_en & enabled & ~restart;

  resync_stage_cnt #(.W(DLY_W)) u_inner (
    .clk(clk), .rst_n(rst_n), .clr(restart | ~enabled),
    .step(count_step), .lim(delay_i), .last(in_last)
  );

  resync_stage_cnt #(.W(MULT_W)) u_outer (
    .clk(clk), .rst_n(rst_n), .clr(restart | ~enabled),
    .step(count_step & in_last), .lim(mult_i), .last(out_last)
  );

  assign hit = count_step & in_last & out_last;

  resync_arm u_arm (
    .clk(clk), .rst_n(rst_n), .enabled(enabled),
    .arm(load_rise & enabled), .hit(hit),
    .apply_d(apply_d), .pending(pending_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      apply_q <= 1'b0;
    end else begin
      sync_q  <= hit;
      apply_q <= apply_d;
    end
  end

  assign sync_o  = sync_q;
  assign apply_o = apply_q;

  // R10: apply never appears alone
  a_r10_apply_with_sync: assert property (@(posedge clk) disable iff (!rst_n)
    apply_o |-> sync_o);
  // R3: a disabled configuration yields no pulse next cycle
  a_r3_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled) |=> (!sync_o && !pending_o));
  // R4: a restart cycle never produces a pulse
  a_r4_restart_no_sync: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !sync_o);
  // R5: a load edge while enabled leaves a pending resync
  a_r5_load_arms: assert property (@(posedge clk) disable iff (!rst_n)
    (load_rise && enabled) |=> pending_o);
  // R6: pending drops exactly when apply fires
  a_r6_apply_clears: assert property (@(posedge clk) disable iff (!rst_n)
    apply_o |-> (!pending_o && $past(pending_o)));
endmodule

// File: tb/sim_resync_timer.sv
module sim_resync_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pfd_en = 1'b0;
  logic load_i = 1'b0;
  logic [3:0]  mult_i = '0;
  logic [10:0] delay_i = '0;
  logic sync_o, apply_o, pending_o;

  always #10 clk = ~clk;

  resync_timer u0 (
    .clk(clk), .rst_n(rst_n), .pfd_en(pfd_en), .load_i(load_i),
    .mult_i(mult_i), .delay_i(delay_i),
    .sync_o(sync_o), .apply_o(apply_o), .pending_o(pending_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  int k = 0;
  bit lp = 0;
  int mp = 0, dp = 0;
  bit pend = 0, seen = 0;
  bit last_s, last_a;
  bit done = 0;

  function automatic bit sync_due(int kk, int m, int d);
    if (m == 0 || d == 0) return 1'b0;
    return ((kk + 1) % (m * d)) == 0;
  endfunction

  task automatic chk(string req, bit act, bit exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit en, input bit ld, input int m, input int d);
    bit rise, chg, rs, ena, es, ea;
    @(negedge clk);
    pfd_en = en; load_i = ld; mult_i = 4'(m); delay_i = 11'(d);
    rise = ld && !lp;
    chg  = (m != mp) || (d != dp);
    rs   = rise || chg;
    ena  = (m != 0) && (d != 0);
    es   = !rs && ena && en && sync_due(k, m, d);
    ea   = 1'b0;
    if (!ena) begin pend = 0; seen = 0; end
    else if (rise) begin pend = 1; seen = 0; end
    else if (es && pend) begin
      if (seen) begin ea = 1; pend = 0; seen = 0; end
      else seen = 1;
    end
    if (rs || !ena) k = 0;
    else if (en) k = (k + 1) % (m * d);
    lp = ld; mp = m; dp = d;
    @(posedge clk); #1;
    chk("R1 sync", sync_o, es);
    chk("R6 apply", apply_o, ea);
    chk("R5 pending", pending_o, pend);
    if (apply_o && !sync_o) chk("R10 apply alone", 1'b1, 1'b0);
    last_s = sync_o; last_a = apply_o;
  endtask

  initial begin
    int syncs, applies;
    void'($urandom(32'h1234_5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 reset sync", sync_o, 1'b0);
    chk("R6 reset apply", apply_o, 1'b0);
    chk("R5 reset pending", pending_o, 1'b0);

    // R3: disabled, load edges ignored
    for (int i = 0; i < 40; i++) step(1'b1, i[2], 0, 5);
    for (int i = 0; i < 40; i++) step(1'b1, i[2], 3, 0);
    chk("R3 disabled pending", pending_o, 1'b0);

    // R5/R6: arm, first pulse passes, second applies (m=2,d=3 -> 6)
    step(1'b1, 1'b0, 2, 3);
    step(1'b1, 1'b1, 2, 3);
    for (int i = 0; i < 14; i++) step(1'b1, 1'b0, 2, 3);

    // R2: enable low stretch does not advance
    step(1'b1, 1'b1, 2, 3);
    for (int i = 0; i < 20; i++) step(i % 4 == 0, 1'b0, 2, 3);

    // R8: load held high counts once; R7: re-arm before apply
    for (int i = 0; i < 9; i++) step(1'b1, 1'b1, 1, 4);
    step(1'b1, 1'b0, 1, 4);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1, 4);
    step(1'b1, 1'b1, 1, 4);
    chk("R7 rearm pending", pending_o, 1'b1);
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 1, 4);

    // R4: config change mid-interval restarts
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 3, 3);
    step(1'b1, 1'b0, 3, 4);
    for (int i = 0; i < 15; i++) step(1'b1, 1'b0, 3, 4);

    // R9: 10 x 1000 example
    syncs = 0; applies = 0;
    step(1'b1, 1'b0, 10, 1000);
    step(1'b1, 1'b1, 10, 1000);
    for (int i = 0; i < 20000; i++) begin
      step(1'b1, 1'b0, 10, 1000);
      if (last_s) syncs++;
      if (last_a) applies++;
      if (last_s) chk("R9 pulse position", ((i + 1) % 10000) == 0, 1'b1);
    end
    chk("R9 two pulses", syncs == 2, 1'b1);
    chk("R9 one apply", applies == 1, 1'b1);

    // random mix
    for (int s = 0; s < 600; s++) begin
      int m, d, len;
      m = $urandom_range(0, 4);
      d = $urandom_range(0, 6);
      len = $urandom_range(10, 80);
      for (int i = 0; i < len; i++)
        step($urandom_range(0, 9) < 7, $urandom_range(0, 19) == 0, m, d);
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule